// File: doc/BRIEF.md
# Processor Clock-Domain Gating Controller

This block produces one clock-enable per clock domain of a processor (core, data cache, snoop logic, time base/decrementer and peripherals). The enables are chosen by the active low-power mode. The modes are graded, and each one keeps a fixed subset of domains clocked. One mode keeps every domain running but lets the core tick only once per four bus cycles. The glitch-free gating cells and the clock tree sit outside this block. It supplies only the enable levels and the divide-by-four tick.

Software programs a target mode and two arming bits through a small register write port. A mode is entered on the rising edge of a trigger whose own arming bit is set. One trigger is an external power-down pin and the other is a power-down instruction strobe. A wake input returns the controller to full run on the next cycle and disarms both triggers, so a second entry needs the register to be written again.

Top module: `pcg_ctrl`

## Requirements
- R1: During and after reset the mode is run, all five enables are high and both arming bits are clear.
- R2: Enable bit positions are: bit0 core, bit1 data cache, bit2 snoop, bit3 time base/decrementer, bit4 peripherals. In run mode all five enables are high. Write data fields: bits[2:0] target mode code, bit3 pin arming, bit4 instruction arming. Mode codes: 0 run, 1 reduced, 2 doze, 3 nap, 4 sleep, 5 cpu-sleep.
- R3: In reduced mode, bits 4..1 are high and the core enable is high for exactly one cycle in every four, driven by a free-running counter that starts at reset and pulses on its fourth count.
- R4: In doze mode the enables equal 5'b01110 (data cache, snoop and time base only).
- R5: In nap mode the enables equal 5'b01000 (time base only).
- R6: In sleep mode the enables equal 5'b00000.
- R7: In cpu-sleep mode the enables equal 5'b11110 (core stopped, everything else running).
- R8: Target codes 6 and 7 are stored as run, so entering them leaves all enables high.
- R9: A rising edge on the pin input, sampled at a clock edge while the pin arming bit is set, makes the programmed target mode active from that same clock edge.
- R10: A rising edge on the instruction strobe while the instruction arming bit is set enters the target mode in the same way.
- R11: A trigger whose own arming bit is clear is ignored, even when the other arming bit is set.
- R12: A trigger held high causes no further entry. A new target written while the pin stays high does not take effect.
- R13: Wake sampled at a clock edge forces run mode with all enables high from that edge and clears both arming bits. Wake wins over a trigger edge and over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 5 | Control register write data (mode code, pin arm, instruction arm) |
| pd_insn_i | input | 1 | Power-down instruction strobe |
| pd_pin_i | input | 1 | External power-down pin |
| wake_i | input | 1 | Wake request, returns to run |
| clk_en_o | output | 5 | Per-domain clock enables |

## Verification
The bench targets trigger qualification. It sends a pin edge while only the instruction arm is set, and holds the pin high across a new register write. A design that detected levels instead of edges would re-enter modes, and one that ORed the arming bits would enter on the wrong trigger. It also fires wake together with a trigger and a write, and then retriggers after wake. A design that gave the trigger priority or kept the arm bits would end in a low-power mode where run is expected. In reduced mode, every core enable is compared with a cycle count kept since reset, which exposes a wrong divide ratio or a stuck tick. Illegal codes 6 and 7 are entered to catch decoders that map them onto a gated mask.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int N_DOM    = 5;
  localparam int MODE_W   = 3;
  localparam int MAX_CODE = 5;
  localparam int PIN_ARM_BIT = MODE_W;
  localparam int INS_ARM_BIT = MODE_W + 1;
  localparam int CFG_W    = MODE_W + 2;

  localparam int D_CORE  = 0;
  localparam int D_DCACHE = 1;
  localparam int D_SNOOP = 2;
  localparam int D_TB    = 3;
  localparam int D_PERIPH = 4;

  typedef enum logic [MODE_W-1:0] {
    M_RUN    = 3'd0,
    M_RED    = 3'd1,
    M_DOZE   = 3'd2,
    M_NAP    = 3'd3,
    M_SLEEP  = 3'd4,
    M_CPUSLP = 3'd5
  } pmode_e;

  function automatic pmode_e legalize(logic [MODE_W-1:0] code);
    if (code > MODE_W'(MAX_CODE)) return M_RUN;
    return pmode_e'(code);
  endfunction
endpackage

// File: rtl/pcg_cfg_reg.sv
module pcg_cfg_reg
  import pcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wake_i,
  output pmode_e           tgt_mode_o,
  output logic             pin_arm_o,
  output logic             ins_arm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_mode_o <= M_RUN;
      pin_arm_o  <= 1'b0;
      ins_arm_o  <= 1'b0;
    end else if (wake_i) begin
      pin_arm_o  <= 1'b0;
      ins_arm_o  <= 1'b0;
    end else if (we_i) begin
      tgt_mode_o <= legalize(wdata_i[MODE_W-1:0]);
      pin_arm_o  <= wdata_i[PIN_ARM_BIT];
      ins_arm_o  <= wdata_i[INS_ARM_BIT];
    end
  end

  // R13: wake disarms both paths
  a_r13_wake_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (!pin_arm_o && !ins_arm_o));

  // R8: illegal codes never stored
  a_r8_tgt_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wake_i && wdata_i[MODE_W-1:0] > MODE_W'(MAX_CODE)) |=> tgt_mode_o == M_RUN);
endmodule

// File: rtl/pcg_mode_fsm.sv
module pcg_mode_fsm
  import pcg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  logic   ins_i,
  input  logic   wake_i,
  input  pmode_e tgt_mode_i,
  input  logic   pin_arm_i,
  input  logic   ins_arm_i,
  output pmode_e mode_o
);
  logic pin_q, ins_q;
  logic pin_rise, ins_rise, fire;

  assign pin_rise = pin_i & ~pin_q;
  assign ins_rise = ins_i & ~ins_q;
  assign fire     = (pin_rise & pin_arm_i) | (ins_rise & ins_arm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      ins_q  <= 1'b0;
      mode_o <= M_RUN;
    end else begin
      pin_q <= pin_i;
      ins_q <= ins_i;
      if (wake_i)    mode_o <= M_RUN;
      else if (fire) mode_o <= tgt_mode_i;
    end
  end

  // R11: no arm, no change
  a_r11_unarmed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_i && !pin_arm_i && !ins_arm_i) |=> $stable(mode_o));

  // R12: a held pin level never re-enters
  a_r12_level_no_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_i && pin_q && !ins_rise) |=> $stable(mode_o));

  // R13: wake returns to run
  a_r13_wake_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> mode_o == M_RUN);
endmodule

// File: rtl/pcg_divider.sv
module pcg_divider #(
  parameter int DIV_RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R3: tick is a single-cycle pulse
  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pcg_mask_dec.sv
module pcg_mask_dec
  import pcg_pkg::*;
(
  input  pmode_e           mode_i,
  input  logic             tick_i,
  output logic [N_DOM-1:0] en_o
);
  logic [N_DOM-1:0] base;

  always_comb begin
    base = '1;
    case (mode_i)
      M_DOZE:   base = N_DOM'((1 << D_DCACHE) | (1 << D_SNOOP) | (1 << D_TB));
      M_NAP:    base = N_DOM'(1 << D_TB);
      M_SLEEP:  base = '0;
      M_CPUSLP: base = ~N_DOM'(1 << D_CORE);
      default:  base = '1;
    endcase
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    if (d == D_CORE) begin : g_core
      assign en_o[d] = base[d] & ((mode_i != M_RED) | tick_i);
    end else begin : g_other
      assign en_o[d] = base[d];
    end
  end
endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int DIV_RATIO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             pd_insn_i,
  input  logic             pd_pin_i,
  input  logic             wake_i,
  output logic [N_DOM-1:0] clk_en_o
);
  pmode_e tgt_mode, mode;
  logic   pin_arm, ins_arm, tick;

  pcg_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .wake_i,
    .tgt_mode_o(tgt_mode), .pin_arm_o(pin_arm), .ins_arm_o(ins_arm)
  );

  pcg_mode_fsm u_fsm (
    .clk_i, .rst_ni,
    .pin_i(pd_pin_i), .ins_i(pd_insn_i), .wake_i,
    .tgt_mode_i(tgt_mode), .pin_arm_i(pin_arm), .ins_arm_i(ins_arm),
    .mode_o(mode)
  );

  pcg_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  pcg_mask_dec u_dec (.mode_i(mode), .tick_i(tick), .en_o(clk_en_o));

  // R13: full enable one edge after wake
  a_r13_wake_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> &clk_en_o);

  // R3: reduced mode gates only the core
  a_r3_reduced_rest_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_RED) |-> (&clk_en_o[N_DOM-1:1] && clk_en_o[D_CORE] == tick));

  // R5: nap leaves at most the time base running
  a_r5_nap_tb_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_NAP) |-> ($onehot0(clk_en_o) && clk_en_o[D_TB]));

  // R6: sleep stops everything
  a_r6_sleep_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_SLEEP) |-> ($countones(clk_en_o) == 0));
endmodule

// File: tb/tb_pcg_ctrl.sv
module tb_pcg_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = '0;
  logic       pd_insn_i = 1'b0;
  logic       pd_pin_i = 1'b0;
  logic       wake_i = 1'b0;
  logic [4:0] clk_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  int m_tgt = 0, m_mode = 0, m_cnt = 0;
  bit m_parm = 0, m_iarm = 0, m_pq = 0, m_iq = 0;

  pcg_ctrl dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [4:0] exp_en(int mode, int cnt);
    case (mode)
      1: return {4'b1111, (cnt == 3) ? 1'b1 : 1'b0};
      2: return 5'b01110;
      3: return 5'b01000;
      4: return 5'b00000;
      5: return 5'b11110;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic string req_of(int mode);
    case (mode)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_en_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(bit we, logic [4:0] wd, bit ins, bit pin, bit wake);
    bit pr, ir;
    pr = pin && !m_pq;
    ir = ins && !m_iq;
    if (wake) m_mode = 0;
    else if ((pr && m_parm) || (ir && m_iarm)) m_mode = m_tgt;
    if (wake) begin
      m_parm = 0; m_iarm = 0;
    end else if (we) begin
      m_tgt = (int'(wd[2:0]) > 5) ? 0 : int'(wd[2:0]);
      m_parm = wd[3]; m_iarm = wd[4];
    end
    m_pq = pin; m_iq = ins;
    m_cnt = (m_cnt + 1) % 4;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic cyc(bit we, logic [4:0] wd, bit ins, bit pin, bit wake, string req);
    cfg_we_i = we; cfg_wdata_i = wd; pd_insn_i = ins; pd_pin_i = pin; wake_i = wake;
    @(posedge clk_i);
    model_step(we, wd, ins, pin, wake);
    @(negedge clk_i);
    check(req, clk_en_o, exp_en(m_mode, m_cnt));
  endtask

  task automatic idle(int n, bit pin, bit ins, string req);
    for (int i = 0; i < n; i++) cyc(0, 5'd0, ins, pin, 0, req);
  endtask

  initial begin
    int ones, prev, adj;
    logic [4:0] wd;
    bit we, ins, pin, wake;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    check("R1", clk_en_o, 5'b11111);
    rst_ni = 1'b1;
    check("R1", clk_en_o, 5'b11111);

    // R1/R11: arms clear after reset, pin edge ignored
    cyc(0, 5'd0, 0, 1, 0, "R11");
    cyc(0, 5'd0, 0, 0, 0, "R11");
    check("R1", clk_en_o, 5'b11111);

    // R9: pin path into doze, effective from the sampling edge
    cyc(1, 5'b01010, 0, 0, 0, "R2");
    cyc(0, 5'd0, 0, 1, 0, "R9");
    check("R9", clk_en_o, 5'b01110);
    // R12: held pin, new target must not take effect
    cyc(1, 5'b01011, 0, 1, 0, "R12");
    idle(3, 1, 0, "R12");
    check("R12", clk_en_o, 5'b01110);

    // R13: wake, then pin retrigger stays in run
    cyc(0, 5'd0, 0, 1, 1, "R13");
    check("R13", clk_en_o, 5'b11111);
    cyc(0, 5'd0, 0, 0, 0, "R13");
    cyc(0, 5'd0, 0, 1, 0, "R13");
    check("R13", clk_en_o, 5'b11111);
    cyc(0, 5'd0, 0, 0, 0, "R13");

    // R10: instruction path into nap
    cyc(1, 5'b10011, 0, 0, 0, "R2");
    cyc(0, 5'd0, 1, 0, 0, "R10");
    check("R10", clk_en_o, 5'b01000);
    cyc(0, 5'd0, 0, 0, 0, "R5");
    // R11: pin edge with only instruction arm is ignored
    cyc(1, 5'b10100, 0, 0, 0, "R5");
    cyc(0, 5'd0, 0, 1, 0, "R11");
    check("R11", clk_en_o, 5'b01000);
    cyc(0, 5'd0, 1, 0, 0, "R6");
    check("R6", clk_en_o, 5'b00000);
    cyc(0, 5'd0, 0, 0, 0, "R6");

    // R7: cpu-sleep
    cyc(0, 5'd0, 0, 0, 1, "R13");
    cyc(1, 5'b10101, 0, 0, 0, "R2");
    cyc(0, 5'd0, 1, 0, 0, "R7");
    check("R7", clk_en_o, 5'b11110);
    cyc(0, 5'd0, 0, 0, 0, "R7");

    // R8: illegal codes 6 and 7
    for (int c = 6; c < 8; c++) begin
      cyc(1, 5'b10000 | 5'(c), 0, 0, 0, "R8");
      cyc(0, 5'd0, 1, 0, 0, "R8");
      check("R8", clk_en_o, 5'b11111);
      cyc(0, 5'd0, 0, 0, 0, "R8");
    end

    // R3: reduced mode, one core tick in four
    cyc(1, 5'b10001, 0, 0, 0, "R2");
    cyc(0, 5'd0, 1, 0, 0, "R3");
    ones = clk_en_o[0]; prev = clk_en_o[0]; adj = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(0, 5'd0, 0, 0, 0, "R3");
      if (clk_en_o[0] && prev == 1) adj++;
      prev = clk_en_o[0];
      ones += clk_en_o[0];
    end
    check("R3", 5'(ones), 5'd4);
    check("R3", 5'(adj), 5'd0);

    // R13: wake beats trigger and write in the same cycle
    cyc(1, 5'b01100, 0, 0, 0, "R3");
    cyc(1, 5'b11100, 0, 1, 1, "R13");
    check("R13", clk_en_o, 5'b11111);
    cyc(0, 5'd0, 1, 0, 0, "R13");
    check("R13", clk_en_o, 5'b11111);
    cyc(0, 5'd0, 0, 0, 0, "R13");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      we   = ($urandom % 6) == 0;
      wd   = 5'($urandom);
      ins  = ($urandom % 4) == 0;
      pin  = ($urandom % 4) == 0;
      wake = ($urandom % 20) == 0;
      cyc(we, wd, ins, pin, wake, wake ? "R13" : req_of(m_mode));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule